// File: doc/BRIEF.md
# Inclusive Address Range Fill Engine

This block sets every entry of a 64K-entry table, from a lower address up to an upper address with both ends included, to one value. The table can hold data bytes or per-address attribute codes. The engine owns no storage of its own. It drives a write port that carries a 16-entry block index, a 16-bit per-entry write mask and the fill value. The attached table applies the masked write within the selected block.

A request is made by pulsing `start_i` while the engine is idle, with both addresses and the value on the inputs. The engine walks the range in ascending order. An address whose low nibble is zero starts an aligned 16-entry group. When the engine sits on such an address and the whole group lies inside the range, it writes the group in one cycle. Otherwise it writes one entry per cycle. The range therefore splits into a partial head, whole interior groups and a partial tail.

A request whose lower address is greater than its upper address writes nothing. It only produces the completion pulse.

Top module: `range_fill`

## Requirements
- R1: After reset `busy_o`, `done_o` and `wr_en_o` are all 0.
- R2: For a request with lo <= hi, every address in lo..hi (both included) is written exactly once, and no address outside that range is written. Entry e of block b is address b*16+e. Mask bit e selects entry e.
- R3: For a request with lo > hi, there is no write and `busy_o` stays 0. `done_o` is 1 for exactly the one cycle after the sampling edge.
- R4: When the current address has low nibble 0 and that address plus 15 is <= hi, the engine makes one write with mask 16'hFFFF. Otherwise each write has exactly one mask bit set, at the position of the current low nibble. The number of write cycles therefore equals the count of whole groups inside the range plus the count of range entries outside such groups.
- R5: `start_i` is ignored while `busy_o` is 1. A pulse during a fill does not change the range or the value being written.
- R6: `done_o` is 1 for one cycle, in the cycle after the last write. `busy_o` falls at that same edge.
- R7: Writes come in strictly ascending address order. A range that ends at 0xFFFF ends there and never wraps to 0x0000.
- R8: When lo and hi differ only in the lowest nibble, every write goes to the single block lo[15:4].
- R9: `wr_data_o` equals the value sampled with the start. Changes on `value_i` during a fill have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, sampled only while idle |
| lo_addr_i | input | 16 | First address of the range |
| hi_addr_i | input | 16 | Last address of the range |
| value_i | input | DW | Fill value |
| busy_o | output | 1 | Fill in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wr_en_o | output | 1 | Table write strobe |
| wr_blk_o | output | 12 | Index of the 16-entry block being written |
| wr_mask_o | output | 16 | Per-entry write enables within the block |
| wr_data_o | output | DW | Value to write |

## Verification
The assertions check four things on every cycle:
- each mask is either full or one-hot;
- no write passes the latched upper address;
- successive writes move strictly upward;
- the latched range holds while a stray start arrives and `done_o` never lasts two cycles.

Only the bench scenarios can show the following:
- the whole range is covered with no gaps, which the bench checks against a write count it computes from the block split;
- a reversed range does nothing;
- a fill ending at 0xFFFF stops cleanly;
- a narrow range stays inside one block.

// File: rtl/range_fill.sv
module range_fill #(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int NB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AW-1:0]    lo_addr_i,
  input  logic [AW-1:0]    hi_addr_i,
  input  logic [DW-1:0]    value_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             wr_en_o,
  output logic [AW-NB-1:0] wr_blk_o,
  output logic [(1<<NB)-1:0] wr_mask_o,
  output logic [DW-1:0]    wr_data_o
);
  localparam int BLK = 1 << NB;
  localparam logic [AW:0] SPAN = (AW+1)'(BLK - 1);

  logic          busy_q, done_q;
  logic [AW-1:0] cur_q, end_q;
  logic [DW-1:0] val_q;

  logic          aligned, full_blk, last;
  logic [AW:0]   blk_last;
  logic [AW-1:0] step_last;

  assign aligned   = (cur_q[NB-1:0] == '0);
  assign blk_last  = {1'b0, cur_q} + SPAN;
  assign full_blk  = aligned && (blk_last <= {1'b0, end_q});
  assign step_last = full_blk ? blk_last[AW-1:0] : cur_q;
  assign last      = (step_last == end_q);

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign wr_en_o   = busy_q;
  assign wr_blk_o  = cur_q[AW-1:NB];
  assign wr_mask_o = full_blk ? {BLK{1'b1}} : ({{(BLK-1){1'b0}}, 1'b1} << cur_q[NB-1:0]);
  assign wr_data_o = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cur_q  <= '0;
      end_q  <= '0;
      val_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          cur_q <= lo_addr_i;
          end_q <= hi_addr_i;
          val_q <= value_i;
          if (lo_addr_i > hi_addr_i) done_q <= 1'b1;
          else                       busy_q <= 1'b1;
        end
      end else if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cur_q <= step_last + 1'b1;
      end
    end
  end

  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_mask_o == {BLK{1'b1}} || $onehot(wr_mask_o))); // R4
  AST_WITHIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ({wr_blk_o, {NB{1'b0}}} <= end_q)); // R2
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && $past(wr_en_o)) |-> (cur_q > $past(cur_q))); // R7
  AST_RANGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(end_q) && $stable(val_q))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
endmodule

// File: tb/test_range_fill.sv
module test_range_fill;
  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [15:0] lo_addr_i = '0, hi_addr_i = '0;
  logic [7:0] value_i = '0;
  logic busy_o, done_o, wr_en_o;
  logic [11:0] wr_blk_o;
  logic [15:0] wr_mask_o;
  logic [7:0] wr_data_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int min_blk, max_blk;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  range_fill #(.DW(8), .AW(16), .NB(4)) i_range_fill (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lo_addr_i(lo_addr_i),
    .hi_addr_i(hi_addr_i), .value_i(value_i), .busy_o(busy_o), .done_o(done_o),
    .wr_en_o(wr_en_o), .wr_blk_o(wr_blk_o), .wr_mask_o(wr_mask_o), .wr_data_o(wr_data_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_writes(input int lo, input int hi);
    int cnt = 0;
    for (int b = lo >> 4; b <= (hi >> 4); b++) begin
      int bs = b * 16;
      int be = bs + 15;
      if (bs >= lo && be <= hi) cnt += 1;
      else cnt += ((be < hi) ? be : hi) - ((bs > lo) ? bs : lo) + 1;
    end
    return cnt;
  endfunction

  task automatic run(input int lo, input int hi, input logic [7:0] val, input bit disturb);
    int next_a = lo, writes = 0, bad_order = 0, bad_mask = 0, bad_data = 0, guard = 0;
    @(negedge clk);
    lo_addr_i = lo[15:0]; hi_addr_i = hi[15:0]; value_i = val; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    min_blk = 4096; max_blk = -1;
    if (lo > hi) begin
      chk(done_o == 1'b1, "R3 done after reversed", int'(done_o), 1);
      chk(busy_o == 1'b0 && wr_en_o == 1'b0, "R3 no write on reversed", int'(wr_en_o), 0);
      @(negedge clk);
      chk(done_o == 1'b0 && wr_en_o == 1'b0, "R3 done one cycle", int'(done_o), 0);
      return;
    end
    while (busy_o && guard < 5000) begin
      guard++;
      if (disturb && writes == 1) begin
        start_i = 1'b1; lo_addr_i = 16'h0000; hi_addr_i = 16'hFFFF; value_i = ~val;
      end else begin
        start_i = 1'b0; value_i = ~val;
      end
      if (wr_en_o) begin
        int base = int'(wr_blk_o) * 16;
        writes++;
        if (int'(wr_blk_o) < min_blk) min_blk = int'(wr_blk_o);
        if (int'(wr_blk_o) > max_blk) max_blk = int'(wr_blk_o);
        if (wr_data_o != val) bad_data++;
        if (wr_mask_o == 16'hFFFF) begin
          if (base != next_a || base + 15 > hi) bad_order++;
          next_a = base + 16;
        end else if ($countones(wr_mask_o) == 1) begin
          int e = 0;
          for (int k = 0; k < 16; k++) if (wr_mask_o[k]) e = k;
          if (base + e != next_a || base + e > hi) bad_order++;
          next_a = base + e + 1;
        end else bad_mask++;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(guard < 5000, "R6 fill ends", guard, 0);
    chk(bad_order == 0 && next_a == hi + 1, "R2 R7 coverage in order", next_a, hi + 1);
    chk(bad_mask == 0, "R4 mask shape", bad_mask, 0);
    chk(writes == exp_writes(lo, hi), "R4 write cycles", writes, exp_writes(lo, hi));
    chk(bad_data == 0, "R9 data held", bad_data, 0);
    chk(done_o == 1'b1 && busy_o == 1'b0, "R6 done after last write", int'(done_o), 1);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0 && wr_en_o == 1'b0, "R6 R5 idle after done", int'(busy_o), 0);
  endtask

  initial begin
    #7;
    chk(busy_o == 0 && done_o == 0 && wr_en_o == 0, "R1 reset state", int'(busy_o), 0);
    rst_n = 1'b1;
    run(16'h1234, 16'h1234, 8'h11, 1'b0);
    run(16'h5A03, 16'h5A0C, 8'h22, 1'b0);
    chk(min_blk == 16'h5A0 && max_blk == 16'h5A0, "R8 single block", max_blk, 16'h5A0);
    run(16'h1230, 16'h123F, 8'h33, 1'b0);
    chk(min_blk == max_blk, "R8 R4 whole group one block", max_blk, min_blk);
    run(16'h12F8, 16'h1407, 8'h44, 1'b0);
    run(16'h2000, 16'h1FFF, 8'h55, 1'b0);
    run(16'hFFFA, 16'hFFFF, 8'h66, 1'b0);
    run(16'hFFF0, 16'hFFFF, 8'h77, 1'b0);
    run(16'h0000, 16'h00FF, 8'h88, 1'b0);
    run(16'h0305, 16'h0398, 8'h99, 1'b1);
    run(16'h0FE1, 16'h300E, 8'hAA, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule